// File: doc/BRIEF.md
# I2C SCL Period Generator

This block sets the timing of the serial clock for an I2C bus master. The peripheral clock is first divided by a small programmable factor (1 + prescale) to form an internal tick. A period counter then walks through one SCL period of `20 + 8*step + comp` internal ticks. The `step` and prescale fields come from one packed divider word, and `comp` is a small count of compensation ticks for rise time, fall time and internal delay.

Each SCL period is split into a low half and a high half. The low half gets the odd tick when the period length is odd. The block emits four single-cycle strobes: SCL falling, SDA change (middle of the low half), SCL rising, and SDA sample (middle of the high half). The master's state machine and line drivers use these strobes.

No strobe is produced until the divider word has been written at least once. A new divider word, or a new compensation value, takes effect only at the boundary between two periods. Deasserting the master enable clears all counters and stops the strobes.

Top module: `scl_rate_gen`

## Requirements
- R1: Internal ticks occur every (1 + PRE) peripheral clocks, where PRE is the low CDF_W bits (bits [2:0] at the default CDF_W = 3) of the divider word.
- R2: With STEP taken from the six bits directly above PRE (bits [8:3] at default), consecutive `scl_fall` strobes are (1+PRE)*(20 + 8*STEP + COMP) clocks apart.
- R3: `scl_rise` follows `scl_fall` by (1+PRE)*L clocks, where L = ceil(P/2) and P is the period in ticks; at most one strobe is active in any cycle.
- R4: `sda_change` follows `scl_fall` by (1+PRE)*floor(L/2) clocks.
- R5: `sda_sample` follows `scl_fall` by (1+PRE)*(L + floor((P-L)/2)) clocks.
- R6: After reset all strobes are low and remain low while no divider word has been written, even with `enable` high. With `enable` high, a write makes the first `scl_fall` appear (PRE+2) clocks after the clock edge that captures the write.
- R7: Divider and compensation changes apply only at a period boundary. A write captured on the same edge as the last tick of a period governs the very next period. A write captured one edge later leaves that next period at the old length and applies to the one after.
- R8: While `enable` is low, no strobe is output from the next clock on. When `enable` rises again with a valid divider word, the first `scl_fall` appears (PRE+1) clocks after the edge that captures `enable` high.
- R9: COMP (0 to 15) is captured together with the divider fields, both while stopped and at each period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Master enable; low clears counters and silences strobes |
| cfg_we | input | 1 | Divider word write strobe |
| cfg_data | input | CDF_W+6 | Divider word: {STEP[5:0], PRE[CDF_W-1:0]} |
| comp_cycles | input | 4 | Rise/fall/delay compensation ticks |
| scl_fall | output | 1 | One-cycle strobe: SCL goes low |
| sda_change | output | 1 | One-cycle strobe: SDA may change (mid-low) |
| scl_rise | output | 1 | One-cycle strobe: SCL goes high |
| sda_sample | output | 1 | One-cycle strobe: sample SDA (mid-high) |

## Verification
The collision that matters is a divider-word write landing on the same clock edge as the period-ending tick, which also reloads the active configuration. The bench times a write to hit exactly that edge and checks that the next fall-to-fall interval already has the new length. It then repeats the write one edge late and checks that one full period at the old length comes first. A table of prescale, step and compensation vectors covers odd and even periods, the largest step, and the largest prescale.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    localparam int CDF_MAX_W = 3;
    localparam int STEP_W    = 6;
    localparam int COMP_W    = 4;
    localparam int BASE_CYC  = 20;
    localparam int STEP_MUL  = 8;
    localparam int MAX_PER   = BASE_CYC + STEP_MUL * ((1 << STEP_W) - 1) + (1 << COMP_W) - 1;
    localparam int PER_W     = $clog2(MAX_PER + 1);

    typedef struct packed {
        logic [CDF_MAX_W-1:0] pre;
        logic [STEP_W-1:0]    step;
        logic [COMP_W-1:0]    comp;
    } div_cfg_t;

    typedef struct packed {
        logic [PER_W-1:0] period;
        logic [PER_W-1:0] low;
        logic [PER_W-1:0] chg;
        logic [PER_W-1:0] smp;
    } phase_pts_t;

    function automatic phase_pts_t calc_points(input div_cfg_t c);
        phase_pts_t r;
        logic [PER_W-1:0] high;
        r.period = PER_W'(BASE_CYC) + (PER_W'(c.step) << 3) + PER_W'(c.comp);
        high     = r.period >> 1;
        r.low    = r.period - high;
        r.chg    = r.low >> 1;
        r.smp    = r.low + (high >> 1);
        return r;
    endfunction

endpackage

// File: rtl/scl_div_cfg.sv
module scl_div_cfg
    import scl_gen_pkg::*;
#(
    parameter int CDF_W = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      enable,
    input  logic                      cfg_we,
    input  logic [CDF_W+STEP_W-1:0]   cfg_data,
    input  logic [COMP_W-1:0]         comp_in,
    input  logic                      boundary,
    output div_cfg_t                  act,
    output logic                      running
);
    localparam int WORD_W = CDF_W + STEP_W;

    logic [WORD_W-1:0]    word_q;
    logic                 word_valid;
    logic [WORD_W-1:0]    src;
    logic [CDF_MAX_W-1:0] pre_ext;
    div_cfg_t             next_cfg;

    assign src = cfg_we ? cfg_data : word_q;

    generate
        if (CDF_W < CDF_MAX_W) begin : g_narrow
            assign pre_ext = {{(CDF_MAX_W-CDF_W){1'b0}}, src[CDF_W-1:0]};
        end else begin : g_full
            assign pre_ext = src[CDF_MAX_W-1:0];
        end
    endgenerate

    always_comb begin
        next_cfg.pre  = pre_ext;
        next_cfg.step = src[CDF_W +: STEP_W];
        next_cfg.comp = comp_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q     <= '0;
            word_valid <= 1'b0;
            running    <= 1'b0;
            act        <= '0;
        end else begin
            if (cfg_we) begin
                word_q     <= cfg_data;
                word_valid <= 1'b1;
            end
            running <= enable && word_valid;
            if (!running || boundary)
                act <= next_cfg;
        end
    end

    AST_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> !running);  // R6
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (running && !boundary) |=> $stable(act));  // R7

endmodule

// File: rtl/scl_prescale.sv
module scl_prescale
    import scl_gen_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 running,
    input  logic [CDF_MAX_W-1:0] pre,
    output logic                 tick
);
    logic [CDF_MAX_W-1:0] cnt;

    assign tick = running && (cnt == pre);

    always_ff @(posedge clk) begin
        if (rst || !running)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt <= pre));  // R1
    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));  // R1

endmodule

// File: rtl/scl_phase.sv
module scl_phase
    import scl_gen_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     running,
    input  logic     tick,
    input  div_cfg_t act,
    output logic     boundary,
    output logic     fall_o,
    output logic     chg_o,
    output logic     rise_o,
    output logic     smp_o
);
    phase_pts_t       pts;
    logic [PER_W-1:0] pos;
    logic             last;

    assign pts      = calc_points(act);
    assign last     = (pos == pts.period - 1'b1);
    assign boundary = tick && last;

    always_ff @(posedge clk) begin
        if (rst || !running)
            pos <= '0;
        else if (tick)
            pos <= last ? '0 : pos + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            fall_o <= 1'b0;
            chg_o  <= 1'b0;
            rise_o <= 1'b0;
            smp_o  <= 1'b0;
        end else begin
            fall_o <= tick && (pos == '0);
            chg_o  <= tick && (pos == pts.chg);
            rise_o <= tick && (pos == pts.low);
            smp_o  <= tick && (pos == pts.smp);
        end
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
        running |-> (pos < pts.period));  // R2
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fall_o, chg_o, rise_o, smp_o}));  // R3

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_gen_pkg::*;
#(
    parameter int CDF_W = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    enable,
    input  logic                    cfg_we,
    input  logic [CDF_W+STEP_W-1:0] cfg_data,
    input  logic [COMP_W-1:0]       comp_cycles,
    output logic                    scl_fall,
    output logic                    sda_change,
    output logic                    scl_rise,
    output logic                    sda_sample
);
    div_cfg_t act;
    logic     running;
    logic     tick;
    logic     boundary;

    scl_div_cfg #(.CDF_W(CDF_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .cfg_we   (cfg_we),
        .cfg_data (cfg_data),
        .comp_in  (comp_cycles),
        .boundary (boundary),
        .act      (act),
        .running  (running)
    );

    scl_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .running (running),
        .pre     (act.pre),
        .tick    (tick)
    );

    scl_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .running  (running),
        .tick     (tick),
        .act      (act),
        .boundary (boundary),
        .fall_o   (scl_fall),
        .chg_o    (sda_change),
        .rise_o   (scl_rise),
        .smp_o    (sda_sample)
    );

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !(scl_fall || sda_change || scl_rise || sda_sample));  // R8

endmodule

// File: tb/scl_rate_gen_test.sv
module scl_rate_gen_test;
    localparam int CDF_W   = 3;
    localparam int NVEC    = 6;
    localparam int WAIT_MX = 6000;

    localparam int V_PRE  [NVEC] = '{0, 1, 3, 7, 2, 0};
    localparam int V_STEP [NVEC] = '{0, 0, 2, 1, 63, 5};
    localparam int V_COMP [NVEC] = '{0, 7, 5, 15, 15, 0};
    localparam int V_PER  [NVEC] = '{20, 27, 41, 43, 539, 60};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic cfg_we = 1'b0;
    logic [CDF_W+5:0] cfg_data = '0;
    logic [3:0] comp_cycles = '0;
    logic scl_fall, sda_change, scl_rise, sda_sample;

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scl_rate_gen #(.CDF_W(CDF_W)) uut (
        .clk(clk), .rst(rst), .enable(enable), .cfg_we(cfg_we),
        .cfg_data(cfg_data), .comp_cycles(comp_cycles),
        .scl_fall(scl_fall), .sda_change(sda_change),
        .scl_rise(scl_rise), .sda_sample(sda_sample)
    );

    task automatic chk(input string req, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic logic sel(input int which);
        case (which)
            0:       return scl_fall;
            1:       return sda_change;
            2:       return scl_rise;
            default: return sda_sample;
        endcase
    endfunction

    task automatic wait_evt(input int which, output int t);
        t = -1;
        for (int g = 0; g < WAIT_MX; g++) begin
            @(negedge clk);
            if (sel(which)) begin
                t = cyc;
                break;
            end
        end
        if (t < 0) begin
            nerr++;
            $display("FAIL strobe %0d timeout: got none expected one", which);
        end
    endtask

    task automatic count_strobes(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (scl_fall || sda_change || scl_rise || sda_sample) c++;
        end
    endtask

    task automatic write_word(input int pre, input int step);
        cfg_data = {6'(step), 3'(pre)};
        cfg_we   = 1'b1;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int t0, t1, t2, t3, t4, e, c, m, p, l, h, w, j, k;

        // Reset state and unconfigured silence (R6)
        repeat (3) @(negedge clk);
        chk("R6 reset strobes", {28'd0, scl_fall, sda_change, scl_rise, sda_sample}, 0);
        rst = 1'b0;
        enable = 1'b1;
        count_strobes(60, c);
        chk("R6 no word, no strobes", c, 0);

        // First write with enable high: fall at write edge + PRE + 2 (R6)
        w = cyc + 1;
        write_word(1, 0);
        wait_evt(0, j);
        chk("R6 first fall latency", j, w + 1 + 2);

        // Write on the wrap edge applies to the next period (R7): T 40 -> 56
        repeat (40 - 1 - 2) @(posedge clk);
        @(negedge clk);
        write_word(1, 1);
        wait_evt(0, k);
        chk("R7 current period kept", k - j, 40);
        wait_evt(0, t1);
        chk("R7 wrap-edge write applied", t1 - k, 56);

        // Write one edge late waits a full period (R7): 56 -> 40
        k = t1;
        repeat (56 - 1 - 1) @(posedge clk);
        @(negedge clk);
        write_word(1, 0);
        wait_evt(0, t2);
        chk("R7 late write current", t2 - k, 56);
        wait_evt(0, t3);
        chk("R7 late write deferred", t3 - t2, 56);
        wait_evt(0, t4);
        chk("R7 late write applied", t4 - t3, 40);

        // Disable silences strobes (R8)
        @(negedge clk);
        enable = 1'b0;
        count_strobes(200, c);
        chk("R8 disabled silent", c, 0);

        // Vector table (R1 R2 R3 R4 R5 R8 R9)
        for (int v = 0; v < NVEC; v++) begin
            m = 1 + V_PRE[v];
            p = V_PER[v];
            l = p - p / 2;
            h = p / 2;
            @(negedge clk);
            enable = 1'b0;
            comp_cycles = 4'(V_COMP[v]);
            write_word(V_PRE[v], V_STEP[v]);
            repeat (3) @(negedge clk);
            enable = 1'b1;
            e = cyc + 1;
            wait_evt(0, t0);
            chk("R8 restart latency", t0, e + m);
            wait_evt(1, t1);
            chk("R4 sda change offset", t1 - t0, m * (l / 2));
            wait_evt(2, t2);
            chk("R3 scl rise offset", t2 - t0, m * l);
            wait_evt(3, t3);
            chk("R5 sda sample offset", t3 - t0, m * (l + h / 2));
            wait_evt(0, t4);
            chk("R1 R2 R9 period", t4 - t0, m * p);
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule